// File: doc/BRIEF.md
# Spindle Motor PI Servo

This block closes the speed loop of a disc spindle motor. On each sample-enable pulse it forms two signed errors. The frequency error is the programmed frequency setpoint minus a selectable source, which is either the measured frequency word or zero. The position error is the clamped buffer-fill setpoint minus the current fill level. A proportional path, two integrators and an overall loop gain combine these errors into a signed 16-bit control word.

A modulator runs on every clock and turns that word into a one-bit drive. The motor responds to the DC content of the drive. In PWM mode the DC content is the duty cycle. In PDM mode it is the pulse density. Two switches select P-only, I-only or PI operation. Each integrator has a base gain and a separate multiplier, so the integrator bandwidth can be set low even at a high sample rate.

Top module: `spindle_servo`

## Requirements
- R1: Frequency error = `freq_set` − source, where the source is `freq_meas` when `freq_src_pll` is 1 and zero when it is 0. The result is saturated to the signed 16-bit range [−32768, 32767].
- R2: The fill setpoint is clamped to the range [118, 128] before use. Position error = clamped setpoint − `fill_lvl`.
- R3: When `p_en` is 1, the proportional term is frequency error + position error. When `p_en` is 0, the proportional term is zero.
- R4: On each sample with `i_en` = 1, the frequency accumulator adds freq_err·`gain_kf`·`mult_kf` and the position accumulator adds pos_err·`gain_ki`·`mult_ki`. Each accumulator contributes its new value arithmetically shifted right by 8.
- R5: While `i_en` is 0, both accumulators are held at zero on every clock, so after re-enabling, integration restarts from zero.
- R6: Each accumulator saturates at −8388608 and 8388607 and never wraps.
- R7: `ctrl_word` = sat16(((P term + integral terms) · `gain_g`) >>> 4). It updates only on the clock edge where `sample_en` is 1 and holds at every other edge.
- R8: The modulator level is `ctrl_word[15:6]` with bit 9 inverted (offset binary, 0..1023). In PWM mode (`mod_pdm` = 0), a free-running 10-bit counter produces exactly `level` high cycles in every 1024-cycle period. The level is latched only when the counter wraps.
- R9: In PDM mode (`mod_pdm` = 1), a first-order sigma-delta on the level produces exactly `level` high cycles in any 1024 consecutive cycles while the level is constant.
- R10: Synchronous reset clears both accumulators and `ctrl_word` to 0, which gives a drive level of 512 (50%).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | One-cycle pulse that recomputes the control word |
| freq_meas | input | 16 | Measured frequency word (unsigned) |
| freq_set | input | 16 | Frequency setpoint (unsigned) |
| freq_src_pll | input | 1 | 1: use the measured frequency as the source, 0: use zero |
| fill_lvl | input | 8 | Buffer fill level |
| fill_set | input | 8 | Fill setpoint (clamped to 118..128) |
| p_en | input | 1 | Proportional path switch |
| i_en | input | 1 | Integral path switch |
| gain_g | input | 8 | Overall loop gain (unsigned, 4 fractional bits) |
| gain_kf | input | 8 | Frequency integrator gain |
| gain_ki | input | 8 | Position integrator gain |
| mult_kf | input | 4 | Frequency integrator gain multiplier |
| mult_ki | input | 4 | Position integrator gain multiplier |
| mod_pdm | input | 1 | 0: PWM, 1: PDM |
| ctrl_word | output | 16 | Signed control word, for observation |
| motor_drive | output | 1 | Modulated motor drive |

## Verification
On every cycle, the assertions check four things:
- the control word holds between sample pulses;
- the accumulators are zero while integration is off and never decrease under a non-negative increment, which would reveal wrap-around;
- the PWM level changes only at the counter wrap;
- the state after reset is correct.

Only the bench's scenarios can show the arithmetic. Those scenarios cover:
- the error sources, the setpoint clamp and the P/I/PI gain products, against a model across sweeps of setpoints, measurements and gains;
- the exact high-cycle counts of both modulators at extreme and mid-range control words.

// File: rtl/spindle_servo_pkg.sv
package spindle_servo_pkg;
    localparam int ERR_W  = 16;
    localparam int ACC_W  = 24;
    localparam int GAIN_W = 8;
    localparam int MULT_W = 4;
    localparam int FILL_W = 8;
    localparam int MOD_W  = 10;
    localparam int WIDE_W = 40;

    localparam int FILL_LO = 118;
    localparam int FILL_HI = 128;

    localparam longint ERR_MAX = (64'sd1 <<< (ERR_W - 1)) - 1;
    localparam longint ERR_MIN = -(64'sd1 <<< (ERR_W - 1));
    localparam longint ACC_MAX = (64'sd1 <<< (ACC_W - 1)) - 1;
    localparam longint ACC_MIN = -(64'sd1 <<< (ACC_W - 1));

    typedef logic signed [ERR_W-1:0]  err_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic signed [WIDE_W-1:0] wide_t;

    typedef struct packed {
        err_t freq;
        err_t pos;
    } err_pair_t;

    typedef enum logic {
        MOD_PWM = 1'b0,
        MOD_PDM = 1'b1
    } mod_kind_e;

    function automatic err_t sat_err(input wide_t v);
        if (v > wide_t'(ERR_MAX))
            return err_t'(ERR_MAX);
        else if (v < wide_t'(ERR_MIN))
            return err_t'(ERR_MIN);
        else
            return err_t'(v);
    endfunction

    function automatic acc_t sat_acc(input wide_t v);
        if (v > wide_t'(ACC_MAX))
            return acc_t'(ACC_MAX);
        else if (v < wide_t'(ACC_MIN))
            return acc_t'(ACC_MIN);
        else
            return acc_t'(v);
    endfunction
endpackage

// File: rtl/spindle_err.sv
module spindle_err
    import spindle_servo_pkg::*;
(
    input  logic [ERR_W-1:0]  freq_meas,
    input  logic [ERR_W-1:0]  freq_set,
    input  logic              freq_src_pll,
    input  logic [FILL_W-1:0] fill_lvl,
    input  logic [FILL_W-1:0] fill_set,
    output err_pair_t         errs
);
    logic [ERR_W-1:0]  src;
    logic [FILL_W-1:0] fill_c;
    wide_t             fdiff;
    wide_t             pdiff;

    always_comb begin
        src = freq_src_pll ? freq_meas : '0;
        fdiff = $signed(WIDE_W'(freq_set)) - $signed(WIDE_W'(src));

        if (fill_set < FILL_W'(FILL_LO))
            fill_c = FILL_W'(FILL_LO);
        else if (fill_set > FILL_W'(FILL_HI))
            fill_c = FILL_W'(FILL_HI);
        else
            fill_c = fill_set;

        pdiff = $signed(WIDE_W'(fill_c)) - $signed(WIDE_W'(fill_lvl));

        errs.freq = sat_err(fdiff);
        errs.pos  = sat_err(pdiff);
    end
endmodule

// File: rtl/spindle_integ.sv
module spindle_integ
    import spindle_servo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              sample,
    input  err_t              err,
    input  logic [GAIN_W-1:0] gain,
    input  logic [MULT_W-1:0] mult,
    output acc_t              acc_nxt,
    output acc_t              acc_q
);
    wide_t inc;

    always_comb begin
        inc = wide_t'(err) * $signed(WIDE_W'(gain)) * $signed(WIDE_W'(mult));
        if (!en)
            acc_nxt = '0;
        else if (sample)
            acc_nxt = sat_acc(wide_t'(acc_q) + inc);
        else
            acc_nxt = acc_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else
            acc_q <= acc_nxt;
    end

    // R5: a disabled integrator is empty on the following clock
    a_r5_clear_when_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> (acc_q == '0));

    // R6: a non-negative increment never makes the accumulator smaller (no wrap)
    a_r6_no_wrap_up: assert property (@(posedge clk) disable iff (rst)
        (en && sample && inc >= 0) |=> (acc_q >= $past(acc_q)));

    // R6: a non-positive increment never makes the accumulator larger
    a_r6_no_wrap_down: assert property (@(posedge clk) disable iff (rst)
        (en && sample && inc <= 0) |=> (acc_q <= $past(acc_q)));
endmodule

// File: rtl/spindle_mod.sv
module spindle_mod
    import spindle_servo_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  mod_kind_e        kind,
    input  logic [MOD_W-1:0] level,
    output logic             drive
);
    localparam logic [MOD_W-1:0] CNT_MAX = '1;
    localparam logic [MOD_W-1:0] MID     = MOD_W'(1) << (MOD_W - 1);

    logic [MOD_W-1:0] cnt_q;
    logic [MOD_W-1:0] duty_q;
    logic [MOD_W-1:0] sd_q;
    logic [MOD_W:0]   sd_sum;
    logic             pwm_bit;

    always_comb begin
        sd_sum  = {1'b0, sd_q} + {1'b0, level};
        pwm_bit = (cnt_q < duty_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            duty_q <= MID;
            sd_q   <= '0;
            drive  <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_MAX)
                duty_q <= level;
            sd_q  <= sd_sum[MOD_W-1:0];
            drive <= (kind == MOD_PDM) ? sd_sum[MOD_W] : pwm_bit;
        end
    end

    // R8: the PWM level is taken over only at the counter wrap
    a_r8_duty_at_wrap: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != CNT_MAX) |=> $stable(duty_q));
endmodule

// File: rtl/spindle_servo.sv
module spindle_servo
    import spindle_servo_pkg::*;
#(
    parameter int ACC_SHIFT = 8,
    parameter int G_SHIFT   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_en,
    input  logic [ERR_W-1:0]  freq_meas,
    input  logic [ERR_W-1:0]  freq_set,
    input  logic              freq_src_pll,
    input  logic [FILL_W-1:0] fill_lvl,
    input  logic [FILL_W-1:0] fill_set,
    input  logic              p_en,
    input  logic              i_en,
    input  logic [GAIN_W-1:0] gain_g,
    input  logic [GAIN_W-1:0] gain_kf,
    input  logic [GAIN_W-1:0] gain_ki,
    input  logic [MULT_W-1:0] mult_kf,
    input  logic [MULT_W-1:0] mult_ki,
    input  logic              mod_pdm,
    output logic [ERR_W-1:0]  ctrl_word,
    output logic              motor_drive
);
    localparam logic [MOD_W-1:0] LVL_FLIP = MOD_W'(1) << (MOD_W - 1);

    err_pair_t        errs;
    acc_t             accf_nxt;
    acc_t             accf_q;
    acc_t             accp_nxt;
    acc_t             accp_q;
    wide_t            p_term;
    wide_t            i_term;
    wide_t            prod;
    err_t             ctrl_d;
    err_t             ctrl_q;
    logic [MOD_W-1:0] level;
    mod_kind_e        kind;

    spindle_err u_err (
        .freq_meas    (freq_meas),
        .freq_set     (freq_set),
        .freq_src_pll (freq_src_pll),
        .fill_lvl     (fill_lvl),
        .fill_set     (fill_set),
        .errs         (errs)
    );

    spindle_integ u_int_freq (
        .clk     (clk),
        .rst     (rst),
        .en      (i_en),
        .sample  (sample_en),
        .err     (errs.freq),
        .gain    (gain_kf),
        .mult    (mult_kf),
        .acc_nxt (accf_nxt),
        .acc_q   (accf_q)
    );

    spindle_integ u_int_pos (
        .clk     (clk),
        .rst     (rst),
        .en      (i_en),
        .sample  (sample_en),
        .err     (errs.pos),
        .gain    (gain_ki),
        .mult    (mult_ki),
        .acc_nxt (accp_nxt),
        .acc_q   (accp_q)
    );

    always_comb begin
        p_term = p_en ? (wide_t'(errs.freq) + wide_t'(errs.pos)) : '0;
        i_term = (wide_t'(accf_nxt) >>> ACC_SHIFT) + (wide_t'(accp_nxt) >>> ACC_SHIFT);
        prod   = (p_term + i_term) * $signed(WIDE_W'(gain_g));
        ctrl_d = sat_err(prod >>> G_SHIFT);
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (sample_en)
            ctrl_q <= ctrl_d;
    end

    always_comb begin
        level     = ctrl_q[ERR_W-1 -: MOD_W] ^ LVL_FLIP;
        kind      = mod_pdm ? MOD_PDM : MOD_PWM;
        ctrl_word = ctrl_q;
    end

    spindle_mod u_mod (
        .clk   (clk),
        .rst   (rst),
        .kind  (kind),
        .level (level),
        .drive (motor_drive)
    );

    // R7: the control word moves only on a sample pulse
    a_r7_hold_between_samples: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> $stable(ctrl_q));

    // R10: leaving reset, control word and both integrators are zero
    a_r10_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (ctrl_q == '0 && accf_q == '0 && accp_q == '0));
endmodule

// File: tb/spindle_servo_bench.sv
module spindle_servo_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sample_en = 1'b0;
    logic [15:0] freq_meas = '0;
    logic [15:0] freq_set = '0;
    logic        freq_src_pll = 1'b1;
    logic [7:0]  fill_lvl = 8'd120;
    logic [7:0]  fill_set = 8'd120;
    logic        p_en = 1'b0;
    logic        i_en = 1'b0;
    logic [7:0]  gain_g = 8'd16;
    logic [7:0]  gain_kf = '0;
    logic [7:0]  gain_ki = '0;
    logic [3:0]  mult_kf = '0;
    logic [3:0]  mult_ki = '0;
    logic        mod_pdm = 1'b0;
    logic [15:0] ctrl_word;
    logic        motor_drive;

    int     errors = 0;
    int     checks = 0;
    bit     done = 1'b0;
    longint macc_f = 0;
    longint macc_p = 0;
    longint last_exp = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spindle_servo u_spindle_servo (
        .clk          (clk),
        .rst          (rst),
        .sample_en    (sample_en),
        .freq_meas    (freq_meas),
        .freq_set     (freq_set),
        .freq_src_pll (freq_src_pll),
        .fill_lvl     (fill_lvl),
        .fill_set     (fill_set),
        .p_en         (p_en),
        .i_en         (i_en),
        .gain_g       (gain_g),
        .gain_kf      (gain_kf),
        .gain_ki      (gain_ki),
        .mult_kf      (mult_kf),
        .mult_ki      (mult_ki),
        .mod_pdm      (mod_pdm),
        .ctrl_word    (ctrl_word),
        .motor_drive  (motor_drive)
    );

    function automatic longint clip(longint v, longint lo, longint hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint ctrl_now();
        return longint'($signed(ctrl_word));
    endfunction

    // One sample pulse. The model is updated from the current inputs and
    // compared with the design one edge later.
    task automatic sample_and_check(string req);
        longint fe, pe, fc, u, exp;
        fc = clip(longint'(fill_set), 118, 128);
        fe = clip(longint'(freq_set) - (freq_src_pll ? longint'(freq_meas) : 0), -32768, 32767);
        pe = fc - longint'(fill_lvl);
        if (i_en) begin
            macc_f = clip(macc_f + fe * longint'(gain_kf) * longint'(mult_kf), -8388608, 8388607);
            macc_p = clip(macc_p + pe * longint'(gain_ki) * longint'(mult_ki), -8388608, 8388607);
        end else begin
            macc_f = 0;
            macc_p = 0;
        end
        u = (p_en ? fe + pe : 0) + (macc_f >>> 8) + (macc_p >>> 8);
        exp = clip((u * longint'(gain_g)) >>> 4, -32768, 32767);
        @(negedge clk) sample_en = 1'b1;
        @(negedge clk) sample_en = 1'b0;
        last_exp = exp;
        check(req, ctrl_now(), exp);
    endtask

    task automatic count_high(int n, output int ones);
        ones = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (motor_drive) ones++;
        end
    endtask

    function automatic longint level_of(longint c);
        return (c + 32768) >>> 6;
    endfunction

    initial begin
        repeat (CLK_PERIOD * 10000 * 2) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int ones;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10: reset state, 50% drive in PWM
        check("R10 ctrl after reset", ctrl_now(), 0);
        count_high(1024, ones);
        check("R10 reset drive density", ones, 512);

        // R1, R3: P-only sweep with the measured-frequency source
        p_en = 1'b1;
        i_en = 1'b0;
        freq_src_pll = 1'b1;
        foreach (gain_g[k]) begin end
        for (int gi = 0; gi < 3; gi++) begin
            gain_g = (gi == 0) ? 8'd16 : ((gi == 1) ? 8'd7 : 8'd255);
            for (int i = 0; i < 16; i++) begin
                freq_set = 16'd30000;
                freq_meas = 16'(i * 4111);
                fill_lvl = 8'(110 + i);
                fill_set = 8'd124;
                sample_and_check("R1 R3 P sweep");
            end
        end

        // R1: zero source and both saturation limits
        gain_g = 8'd16;
        fill_lvl = 8'd124;
        freq_src_pll = 1'b0;
        freq_meas = 16'hFFFF;
        freq_set = 16'd1234;
        sample_and_check("R1 zero source");
        freq_set = 16'hFFFF;
        sample_and_check("R1 positive saturation");
        freq_src_pll = 1'b1;
        freq_set = 16'd0;
        sample_and_check("R1 negative saturation");

        // R2: setpoint clamp sweep, frequency error zero
        freq_set = 16'd5000;
        freq_meas = 16'd5000;
        fill_lvl = 8'd120;
        for (int s = 100; s <= 140; s++) begin
            fill_set = 8'(s);
            sample_and_check("R2 fill clamp");
        end

        // R3: proportional path off gives zero with integrators off
        p_en = 1'b0;
        fill_set = 8'd128;
        fill_lvl = 8'd40;
        sample_and_check("R3 P gated off");
        check("R3 P gated off value", ctrl_now(), 0);

        // R4: I-only accumulation with multipliers
        i_en = 1'b1;
        gain_g = 8'd20;
        gain_kf = 8'd3;
        mult_kf = 4'd5;
        gain_ki = 8'd2;
        mult_ki = 4'd7;
        for (int i = 0; i < 20; i++) begin
            freq_set = 16'd5000;
            freq_meas = 16'(5000 - 300 + i * 37);
            fill_lvl = 8'(118 + (i % 9));
            fill_set = 8'd123;
            sample_and_check("R4 integrate");
        end

        // R4 with PI combined
        p_en = 1'b1;
        for (int i = 0; i < 8; i++) begin
            freq_meas = 16'(5200 - i * 50);
            sample_and_check("R4 R3 PI combined");
        end

        // R7: no sample pulse, inputs move, control word holds
        freq_meas = 16'd100;
        fill_lvl = 8'd0;
        repeat (7) @(negedge clk);
        check("R7 hold without sample", ctrl_now(), last_exp);

        // R6: drive accumulators to the positive limit, then step back
        p_en = 1'b0;
        gain_kf = 8'd255;
        mult_kf = 4'd15;
        gain_ki = 8'd255;
        mult_ki = 4'd15;
        gain_g = 8'd16;
        freq_src_pll = 1'b0;
        freq_set = 16'hFFFF;
        fill_set = 8'd128;
        fill_lvl = 8'd0;
        for (int i = 0; i < 3; i++) sample_and_check("R6 saturate high");
        freq_set = 16'd0;
        fill_lvl = 8'd129;
        gain_kf = 8'd1;
        mult_kf = 4'd1;
        gain_ki = 8'd1;
        mult_ki = 4'd1;
        sample_and_check("R6 no wrap after high limit");
        gain_kf = 8'd255;
        mult_kf = 4'd15;
        freq_src_pll = 1'b1;
        freq_meas = 16'hFFFF;
        gain_ki = 8'd255;
        mult_ki = 4'd15;
        fill_lvl = 8'd255;
        for (int i = 0; i < 4; i++) sample_and_check("R6 saturate low");

        // R5: switch integrators off for a few clocks, then restart from zero
        i_en = 1'b0;
        macc_f = 0;
        macc_p = 0;
        repeat (3) @(negedge clk);
        i_en = 1'b1;
        gain_kf = 8'd1;
        mult_kf = 4'd1;
        gain_ki = 8'd1;
        mult_ki = 4'd1;
        freq_meas = 16'd0;
        freq_set = 16'd0;
        fill_set = 8'd120;
        fill_lvl = 8'd120;
        sample_and_check("R5 restart from zero");
        check("R5 restart value", ctrl_now(), 0);

        // R8, R9: modulator density at several control words
        i_en = 1'b0;
        p_en = 1'b1;
        gain_g = 8'd16;
        freq_src_pll = 1'b1;
        for (int m = 0; m < 2; m++) begin
            mod_pdm = (m == 1);
            for (int c = 0; c < 5; c++) begin
                longint cw;
                cw = (c == 0) ? 0 : (c == 1) ? 12800 : (c == 2) ? -20000 : (c == 3) ? 32767 : -32768;
                if (cw >= 0) begin
                    freq_meas = 16'd0;
                    freq_set = 16'(cw);
                end else begin
                    freq_set = 16'd0;
                    freq_meas = 16'(-cw);
                end
                sample_and_check(m == 0 ? "R8 ctrl setup" : "R9 ctrl setup");
                repeat (2100) @(negedge clk);
                count_high(1024, ones);
                check(m == 0 ? "R8 PWM duty" : "R9 PDM density", ones, level_of(cw));
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule